// File: doc/BRIEF.md
# Variable-Length SPI Shift Engine

This block is a single-lane SPI master shift engine. Each command moves one frame of 1 to 32 bits, either out on MOSI or in from MISO. The engine generates the serial clock itself and times each half period with a programmable divider. Chip select, buffering and bus access belong to the surrounding logic. The host puts an operation, a mode code, a bit count and a transmit word on the command port and raises `cmd_valid`. The command is taken on the first clock edge at which the engine is idle.

Receive frames are returned right-justified in `rdata`, whichever bit order was used on the wire. The mode code picks the bit order. For reads it also picks whether MISO is sampled just before each clock pulse or just after the pulse has returned to idle. The idle level of SCK follows a polarity input whenever the engine is idle. A frame length of zero is a stop request: the engine parks and accepts nothing further until reset.

Top module: `spi_shift_engine`

## Requirements
- R1: In reset and in the first cycle after it: `sck` equals `cfg_cpol`; `mosi`, `busy`, `done`, `halted` and `rx_valid` are 0; `rdata` is 0.
- R2: A write (`cmd_read`=0) with mode 5 sends the low `cmd_count` bits of `cmd_wdata`, most significant first, so the first bit is bit `cmd_count-1`. It produces exactly `cmd_count` SCK pulses, and the slave captures MOSI at each pulse's leading edge.
- R3: A write with mode 4 sends the low `cmd_count` bits, least significant (bit 0) first, with one pulse per bit.
- R4: A read (`cmd_read`=1) with mode 0 or 2 is MSB first. The first bit received lands in bit `cmd_count-1` of `rdata`, and bits above `cmd_count-1` are 0.
- R5: A read with mode 1 or 3 is LSB first. The first bit received lands in bit 0 of `rdata`, and bits above `cmd_count-1` are 0 (right-justified).
- R6: Modes 0 and 1 sample MISO before the leading edge of each pulse. Modes 2 and 3 sample MISO after the trailing edge of that pulse, before the next pulse starts.
- R7: SCK rests at the `cfg_cpol` level while idle, and each pulse leaves that level. The level away from idle lasts `cfg_div` clock cycles, captured at acceptance (0 counts as 1). Every half period lasts that long.
- R8: MOSI is 0 whenever the engine is idle and throughout reads. It is forced to 0 once the last bit of a write has been clocked.
- R9: `busy` is high from the cycle after acceptance until the frame ends. `done` is a one-cycle pulse in the first cycle `busy` is low again. A `cmd_valid` presented while busy is ignored.
- R10: Accepting a valid read clears `rx_valid`. `rdata` and `rx_valid`=1 appear together with `done`. A write leaves `rdata` and `rx_valid` unchanged.
- R11: A command is ignored if it is a write with a mode other than 4 or 5, a read with a mode above 3, or has a count above 32. An ignored command causes no pulse, no `done`, no `busy`, and no change to `rdata` or `rx_valid`.
- R12: A command with `cmd_count`=0 sets `halted`, causes no pulses, and blocks every later command until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_div | input | DIV_W | Half-period length in clocks (0 treated as 1) |
| cmd_valid | input | 1 | Command present |
| cmd_read | input | 1 | 1 = shift-in, 0 = shift-out |
| cmd_mode | input | 3 | Mode code (0..3 read, 4..5 write) |
| cmd_count | input | CNT_W | Frame length, 1..DATA_W; 0 halts |
| cmd_wdata | input | DATA_W | Transmit word |
| miso | input | 1 | Serial data from slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| halted | output | 1 | Engine stopped by zero-length command |
| rx_valid | output | 1 | Receive word available |
| rdata | output | DATA_W | Right-justified receive word |

## Verification
The slave model changes MISO on a different SCK edge for the two sampling families. In pre modes it steps on trailing edges, and in post modes on leading edges. An engine that samples in the wrong phase therefore reads a word shifted by one bit. Reads use non-palindromic values at lengths 1, 7, 17 and 32 under both polarities. This separates MSB-first from LSB-first packing and catches a missing right-justification shift. Writes use words with set bits above the frame length, so sending the wrong slice shows up. The count of cycles with SCK away from idle is compared with the divider setting, including a divider of 0.

// File: rtl/spi_eng_pkg.sv
// Package: shared state encoding, frame kinds and mode codes for the SPI
// shift engine. Mode code values are part of the command interface.
package spi_eng_pkg;

    // Mode codes on cmd_mode.
    localparam logic [2:0] MD_RD_MSB_PRE  = 3'd0;
    localparam logic [2:0] MD_RD_LSB_PRE  = 3'd1;
    localparam logic [2:0] MD_RD_MSB_POST = 3'd2;
    localparam logic [2:0] MD_RD_LSB_POST = 3'd3;
    localparam logic [2:0] MD_WR_LSB      = 3'd4;
    localparam logic [2:0] MD_WR_MSB      = 3'd5;

    // Sequencer state.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SAMP  = 3'd1,
        ST_HALFI = 3'd2,
        ST_HALFA = 3'd3,
        ST_DONE  = 3'd4,
        ST_HALT  = 3'd5
    } eng_state_t;

    // Per-frame bit sequence family.
    typedef enum logic [1:0] {
        K_WRITE   = 2'd0,
        K_RD_PRE  = 2'd1,
        K_RD_POST = 2'd2
    } frame_kind_t;

endpackage

// File: rtl/spi_half_timer.sv
// Half-period timer. Loading starts a window of max(period,1) cycles;
// 'expired' is high in the last cycle of that window.
// Assumes the caller loads on the edge that enters each timed phase.
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] period,
    output logic             expired
);
    logic [DIV_W-1:0] cnt_q;

    // Down-counter: reload on phase entry, then count to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (period == '0) ? '0 : period - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/spi_tx_path.sv
// Transmit path. Owns the MOSI register and the remaining-bits shift
// register. On load the first wire bit appears at once; each step shows the
// next bit; clear forces MOSI low. MSB-first frames are pre-aligned so bit
// (count-1) of the word goes first.
module spi_tx_path #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              msb_first,
    input  logic [CNT_W-1:0]  count,
    input  logic [DATA_W-1:0] word,
    input  logic              step,
    input  logic              clear,
    output logic              mosi
);
    logic [DATA_W-1:0] sr_q;
    logic [DATA_W-1:0] aligned;
    logic [CNT_W:0]    pad;

    assign pad     = (CNT_W+1)'(DATA_W) - {1'b0, count};
    assign aligned = word << pad;

    // MOSI and shift register update: load, advance or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
            mosi <= 1'b0;
        end else if (load) begin
            if (msb_first) begin
                mosi <= aligned[DATA_W-1];
                sr_q <= aligned << 1;
            end else begin
                mosi <= word[0];
                sr_q <= word >> 1;
            end
        end else if (clear) begin
            mosi <= 1'b0;
        end else if (step) begin
            if (msb_first) begin
                mosi <= sr_q[DATA_W-1];
                sr_q <= sr_q << 1;
            end else begin
                mosi <= sr_q[0];
                sr_q <= sr_q >> 1;
            end
        end
    end
endmodule

// File: rtl/spi_rx_path.sv
// Receive path. Accumulates sampled MISO bits. MSB-first frames enter at the
// bottom; LSB-first frames enter at the top and are right-justified by
// (DATA_W - count) on the output.
module spi_rx_path #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              msb_first,
    input  logic [CNT_W-1:0]  count,
    input  logic              miso,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] acc_q;
    logic [CNT_W:0]    pad;

    assign pad = (CNT_W+1)'(DATA_W) - {1'b0, count};

    // Accumulator: clear at frame start, shift in one bit per sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
        end else if (shift) begin
            if (msb_first) acc_q <= {acc_q[DATA_W-2:0], miso};
            else           acc_q <= {miso, acc_q[DATA_W-1:1]};
        end
    end

    assign word = msb_first ? acc_q : (acc_q >> pad);
endmodule

// File: rtl/spi_shift_engine.sv
// SPI master shift engine, top level. Accepts one command while idle and
// runs a frame of 1..DATA_W bits. Each bit is a sequence of timed SCK
// phases plus, for reads, a one-cycle sample slot:
//   write     : idle-half, active-half
//   post read : idle-half, active-half, sample
//   pre read  : sample, active-half, idle-half
// Assumes cfg_div is stable around command acceptance; cfg_cpol is tracked
// only while idle.
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 8,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [2:0]        cmd_mode,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic              halted,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rdata
);
    eng_state_t        state_q, state_d;
    frame_kind_t       kind_q, kind_new;
    logic              msb_q, msb_new;
    logic              cpol_q;
    logic [DIV_W-1:0]  div_q;
    logic [CNT_W-1:0]  count_q, left_q;
    logic              accept, count_ok, mode_ok, start, go_halt;
    logic              last, expired, timer_load, bit_end;
    logic              tx_step, tx_clear;
    logic [DATA_W-1:0] rx_word;

    // Command decode.
    assign accept   = cmd_valid && (state_q == ST_IDLE);
    assign count_ok = (cmd_count != '0) && (cmd_count <= CNT_W'(DATA_W));
    assign mode_ok  = cmd_read ? (cmd_mode <= MD_RD_LSB_POST)
                               : (cmd_mode == MD_WR_LSB || cmd_mode == MD_WR_MSB);
    assign start    = accept && count_ok && mode_ok;
    assign go_halt  = accept && (cmd_count == '0);
    assign kind_new = !cmd_read ? K_WRITE : (cmd_mode[1] ? K_RD_POST : K_RD_PRE);
    assign msb_new  = cmd_read ? ~cmd_mode[0] : cmd_mode[0];
    assign last     = (left_q == CNT_W'(1));

    // Next-state selection for the per-bit phase sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_halt)    state_d = ST_HALT;
                else if (start) state_d = (kind_new == K_RD_PRE) ? ST_SAMP : ST_HALFI;
            end
            ST_SAMP: begin
                if (kind_q == K_RD_PRE) state_d = ST_HALFA;
                else                    state_d = last ? ST_DONE : ST_HALFI;
            end
            ST_HALFI: begin
                if (expired) begin
                    if (kind_q == K_RD_PRE) state_d = last ? ST_DONE : ST_SAMP;
                    else                    state_d = ST_HALFA;
                end
            end
            ST_HALFA: begin
                if (expired) begin
                    unique case (kind_q)
                        K_WRITE:   state_d = last ? ST_DONE : ST_HALFI;
                        K_RD_POST: state_d = ST_SAMP;
                        default:   state_d = ST_HALFI;
                    endcase
                end
            end
            ST_DONE: state_d = ST_IDLE;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_IDLE;
        endcase
    end

    assign bit_end = (state_q == ST_SAMP  && kind_q == K_RD_POST)
                  || (state_q == ST_HALFI && expired && kind_q == K_RD_PRE)
                  || (state_q == ST_HALFA && expired && kind_q == K_WRITE);
    assign timer_load = (state_d == ST_HALFI || state_d == ST_HALFA) && (state_d != state_q);
    assign tx_step  = (kind_q == K_WRITE) && (state_q == ST_HALFA) && expired && !last;
    assign tx_clear = (kind_q == K_WRITE) && (state_q == ST_HALFA) && expired && last;

    // Sequencer state and per-command captured settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_WRITE;
            msb_q   <= 1'b0;
            div_q   <= '0;
            count_q <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                kind_q  <= kind_new;
                msb_q   <= msb_new;
                div_q   <= cfg_div;
                count_q <= cmd_count;
                left_q  <= cmd_count;
            end else if (bit_end) begin
                left_q  <= left_q - 1'b1;
            end
        end
    end

    // Idle clock level: loaded in reset and tracked while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) cpol_q <= cfg_cpol;
    end

    // Receive word, data-ready flag and end-of-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rx_valid <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= (state_q == ST_DONE);
            if (start && cmd_read) begin
                rx_valid <= 1'b0;
            end else if (state_q == ST_DONE && kind_q != K_WRITE) begin
                rdata    <= rx_word;
                rx_valid <= 1'b1;
            end
        end
    end

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .period  ((state_q == ST_IDLE) ? cfg_div : div_q),
        .expired (expired)
    );

    spi_tx_path #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start && !cmd_read),
        .msb_first (msb_new),
        .count     (cmd_count),
        .word      (cmd_wdata),
        .step      (tx_step),
        .clear     (tx_clear),
        .mosi      (mosi)
    );

    spi_rx_path #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start && cmd_read),
        .shift     (state_q == ST_SAMP),
        .msb_first (msb_q),
        .count     (count_q),
        .miso      (miso),
        .word      (rx_word)
    );

    assign sck    = cpol_q ^ (state_q == ST_HALFA);
    assign busy   = (state_q != ST_IDLE) && (state_q != ST_HALT);
    assign halted = (state_q == ST_HALT);
endmodule

// File: rtl/spi_shift_engine_chk.sv
// Checker for spi_shift_engine: port-level temporal properties, bound to
// every instance of the top module.
module spi_shift_engine_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_cpol,
    input logic              sck,
    input logic              mosi,
    input logic              busy,
    input logic              done,
    input logic              halted,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rdata
);
    assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !halted && !$past(busy)) |-> (sck == $past(cfg_cpol)));

    assert_mosi_low_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_rx_valid_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> done);

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata));

    assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !busy));
endmodule

bind spi_shift_engine spi_shift_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_cpol (cfg_cpol),
    .sck      (sck),
    .mosi     (mosi),
    .busy     (busy),
    .done     (done),
    .halted   (halted),
    .rx_valid (rx_valid),
    .rdata    (rdata)
);

// File: tb/tb_spi_shift_engine.sv
`timescale 1ns/1ps
module tb_spi_shift_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpol = 1'b0;
    logic [7:0]  cfg_div = 8'd1;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [2:0]  cmd_mode = 3'd0;
    logic [5:0]  cmd_count = 6'd0;
    logic [31:0] cmd_wdata = '0;
    logic        miso_r = 1'b0;
    logic        sck, mosi, busy, done, halted, rx_valid;
    logic [31:0] rdata;

    int total = 0;
    int fails = 0;

    // Slave model state.
    logic        mon_post = 1'b0;
    logic        mon_read = 1'b0;
    logic        prev_sck = 1'b0;
    logic [31:0] ser = '0;
    logic [63:0] cap = '0;
    int          npulse = 0;
    int          idx = 0;
    int          act_cycles = 0;
    int          mosi_hi = 0;
    int          ndone = 0;

    always #2 clk = ~clk;

    spi_shift_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_div(cfg_div),
        .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_mode(cmd_mode),
        .cmd_count(cmd_count), .cmd_wdata(cmd_wdata), .miso(miso_r),
        .sck(sck), .mosi(mosi), .busy(busy), .done(done), .halted(halted),
        .rx_valid(rx_valid), .rdata(rdata)
    );

    // Slave model: watch SCK edges between clock edges, capture MOSI on
    // leading edges, step MISO on trailing (pre) or leading (post) edges.
    always @(negedge clk) begin
        if (sck !== prev_sck) begin
            if (sck != cfg_cpol) begin
                if (npulse < 64) cap[npulse] = mosi;
                if (mon_post) miso_r = (npulse < 32) ? ser[npulse] : 1'b0;
                npulse++;
            end else if (!mon_post) begin
                idx++;
                miso_r = (idx < 32) ? ser[idx] : 1'b0;
            end
        end
        if (sck != cfg_cpol) act_cycles++;
        if (mon_read && mosi) mosi_hi++;
        if (done) ndone++;
        prev_sck = sck;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] msk(input int c);
        return (c >= 32) ? 32'hFFFF_FFFF : ((32'(1) << c) - 32'(1));
    endfunction

    task automatic set_cpol(input logic p);
        @(negedge clk);
        cfg_cpol = p;
        repeat (3) @(negedge clk);
    endtask

    task automatic arm(input logic rd, input logic post, input logic [31:0] s);
        @(posedge clk);
        #1;
        mon_read = rd; mon_post = post; ser = s;
        npulse = 0; idx = 0; act_cycles = 0; mosi_hi = 0; ndone = 0;
        cap = '0; prev_sck = sck;
        miso_r = post ? 1'b0 : s[0];
    endtask

    task automatic issue(input logic rd, input logic [2:0] md, input int cnt,
                         input logic [31:0] wd, input int dv);
        @(negedge clk);
        cmd_read = rd; cmd_mode = md; cmd_count = cnt[5:0];
        cmd_wdata = wd; cfg_div = dv[7:0]; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(done, req, "done seen", 64'(done), 64'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sck == cfg_cpol && !mosi && !busy && !done && !halted && !rx_valid && rdata == 0,
              "R1", "outputs in reset", {58'd0, sck, mosi, busy, done, halted, rx_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sck == cfg_cpol && !mosi && !busy && !halted && !rx_valid && rdata == 0,
              "R1", "outputs after reset", {32'd0, rdata}, 64'd0);
    endtask

    // Write scenario: used for R2 (mode 5) and R3 (mode 4), and R7/R8.
    task automatic t_write(input logic [2:0] md, input int cnt, input logic [31:0] wd,
                           input int dv, input logic p, input string req);
        logic [31:0] got = '0;
        int dd = (dv == 0) ? 1 : dv;
        logic [31:0] rd_before = rdata;
        logic rv_before = rx_valid;
        set_cpol(p);
        arm(1'b0, 1'b1, '0);
        issue(1'b0, md, cnt, wd, dv);
        check(busy, "R9", "busy after accept", 64'(busy), 64'd1);
        wait_done(req);
        for (int k = 0; k < cnt; k++) begin
            if (md == 3'd5) got[cnt-1-k] = cap[k];
            else            got[k] = cap[k];
        end
        check(got == (wd & msk(cnt)), req, "bits on MOSI", 64'(got), 64'(wd & msk(cnt)));
        check(npulse == cnt, req, "pulse count", 64'(npulse), 64'(cnt));
        check(act_cycles == cnt * dd, "R7", "active-level cycles", 64'(act_cycles), 64'(cnt * dd));
        check(!mosi && sck == p && !busy, "R8", "MOSI low and SCK idle at end",
              {62'd0, mosi, sck}, {63'd0, p});
        check(rdata == rd_before && rx_valid == rv_before, "R10", "write leaves rdata",
              64'(rdata), 64'(rd_before));
        @(negedge clk);
        check(!done, "R9", "done is one cycle", 64'(done), 64'd0);
    endtask

    // Read scenario: R4 (modes 0,2), R5 (modes 1,3), R6 phase via slave model.
    task automatic t_read(input logic [2:0] md, input int cnt, input logic [31:0] val,
                          input int dv, input logic p, input string req);
        logic [31:0] s = '0;
        for (int k = 0; k < cnt; k++) s[k] = md[0] ? val[k] : val[cnt-1-k];
        set_cpol(p);
        arm(1'b1, md[1], s);
        issue(1'b1, md, cnt, 32'hFFFF_FFFF, dv);
        check(!rx_valid && busy, "R10", "rx_valid cleared on accept", 64'(rx_valid), 64'd0);
        wait_done(req);
        check(rdata == (val & msk(cnt)), req, "received word", 64'(rdata), 64'(val & msk(cnt)));
        check(rx_valid, "R10", "rx_valid with done", 64'(rx_valid), 64'd1);
        check(npulse == cnt, "R6", "pulse count on read", 64'(npulse), 64'(cnt));
        check(mosi_hi == 0, "R8", "MOSI low during read", 64'(mosi_hi), 64'd0);
        check(sck == p, "R7", "SCK back at idle", 64'(sck), 64'(p));
    endtask

    task automatic t_busy_ignore();
        logic [31:0] got = '0;
        set_cpol(1'b0);
        arm(1'b0, 1'b1, '0);
        issue(1'b0, 3'd5, 16, 32'h0000_BEEF, 3);
        repeat (4) @(negedge clk);
        cmd_read = 1'b1; cmd_mode = 3'd0; cmd_count = 6'd4; cmd_valid = 1'b1;
        repeat (2) @(negedge clk);
        cmd_valid = 1'b0;
        wait_done("R9");
        for (int k = 0; k < 16; k++) got[15-k] = cap[k];
        check(got == 32'h0000_BEEF && npulse == 16, "R9", "frame unaffected by command while busy",
              64'(got), 64'h0000_BEEF);
        check(rx_valid, "R9", "ignored read did not clear rx_valid", 64'(rx_valid), 64'd1);
        repeat (30) @(negedge clk);
        check(ndone == 1 && npulse == 16, "R9", "no second frame", 64'(ndone), 64'd1);
    endtask

    task automatic t_invalid(input logic rd, input logic [2:0] md, input int cnt, input string what);
        logic [31:0] rd_before = rdata;
        logic rv_before = rx_valid;
        arm(rd, 1'b0, 32'h5555_5555);
        issue(rd, md, cnt, 32'h1234_5678, 2);
        check(!busy, "R11", {what, " busy"}, 64'(busy), 64'd0);
        repeat (40) @(negedge clk);
        check(npulse == 0 && ndone == 0, "R11", {what, " no pulses/done"}, 64'(npulse), 64'd0);
        check(rdata == rd_before && rx_valid == rv_before && !mosi, "R11", {what, " state kept"},
              64'(rdata), 64'(rd_before));
    endtask

    task automatic t_halt();
        arm(1'b0, 1'b1, '0);
        issue(1'b0, 3'd5, 0, 32'hFF, 2);
        check(halted && !busy, "R12", "halted after zero count", 64'(halted), 64'd1);
        issue(1'b0, 3'd5, 8, 32'hFF, 1);
        repeat (40) @(negedge clk);
        check(halted && npulse == 0 && ndone == 0, "R12", "no command accepted when halted",
              64'(npulse), 64'd0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!halted && !busy && !rx_valid, "R12", "reset clears halt", 64'(halted), 64'd0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_write(3'd5, 8, 32'h0000_01A5, 2, 1'b0, "R2");
        t_write(3'd4, 13, 32'hFFFF_1C3B, 1, 1'b1, "R3");
        t_write(3'd5, 32, 32'h8C3A_F015, 3, 1'b0, "R2");
        t_write(3'd4, 5, 32'h0000_0016, 0, 1'b0, "R3");
        t_read(3'd0, 7, 32'h0000_0059, 2, 1'b0, "R4");
        t_read(3'd2, 17, 32'h0001_6A0D, 1, 1'b1, "R4");
        t_read(3'd1, 32, 32'hC0F3_A561, 1, 1'b0, "R5");
        t_read(3'd3, 17, 32'h0000_E2B1, 3, 1'b1, "R5");
        t_read(3'd1, 1, 32'h0000_0001, 2, 1'b1, "R6");
        t_read(3'd2, 32, 32'h9D01_7C4E, 2, 1'b0, "R6");
        t_busy_ignore();
        t_invalid(1'b0, 3'd2, 8, "write mode 2");
        t_invalid(1'b1, 3'd6, 8, "read mode 6");
        t_invalid(1'b0, 3'd5, 40, "count 40");
        t_halt();
        summary();
        $finish;
    end
endmodule